// File: doc/BRIEF.md
# Dual serial chain event flush controller

This block empties the event data that a string of front-end processing modules has latched. Software pulses a start command. The block then drives a shift clock down two serial chains at the same time, and it stops after a programmed number of bits. Each chain returns one bit per shift clock. The block samples that bit on the rising edge of the generated clock, packs the bits into 16-bit words and places each word in a FIFO that belongs to that chain. A host reads each FIFO through a show-ahead read port that carries a read strobe, an empty flag and a fill count.

The shift rate comes from a programmable half-period, counted in system clock cycles. With a 250 MHz system clock, a half-period of 125 gives a 1 Mbit/s transfer. The event length is programmable in bits. A chain holds at most 16 modules, so the length register is sized to cover a full chain. A run that does not end on a word boundary writes one last word: the bits that arrived sit in its upper positions and the remaining low bits are zero.

Top module: `evt_chain_flush`

## Requirements
- R1: After reset the block is idle: busy, done, shift enable and shift clock are low, both FIFOs are empty with a count of 0, and both overflow flags are clear.
- R2: A start pulse seen while idle with a non-zero length makes busy and shift enable high on the next cycle. Shift enable is equal to busy.
- R3: The shift clock starts low. Each low phase and each high phase lasts H system cycles, where H is the programmed half-period, and a value of 0 is treated as 1. The first rising edge comes H cycles after busy rises.
- R4: A run produces exactly as many rising shift clock edges as the programmed bit length. Each chain's serial input is sampled at each of those edges.
- R5: The first bit sampled in a word lands in bit 15 and later bits fill toward bit 0. Every 16 sampled bits form one word, which is written to that chain's FIFO.
- R6: When the length is not a multiple of 16, the last bits are written as one final word. Those bits occupy its upper positions and the unfilled low bits are 0.
- R7: After the high phase of the last bit, the shift clock falls and busy falls in the same cycle, and done rises. Done stays high until the next accepted start clears it.
- R8: A start pulse that arrives while busy is ignored. The run in progress keeps its length and timing.
- R9: A start with a length of 0 sets done on the next cycle. Busy does not rise and no shift clock edge is produced.
- R10: The two chains are handled independently. Each chain's words contain only its own serial input and go only to its own FIFO.
- R11: Each FIFO shows its oldest word on its data output. A read strobe pops that word and the count decreases by one. A read strobe on an empty FIFO has no effect.
- R12: When a chain's FIFO is full, further completed words for that chain are dropped and its overflow flag is set. The flag stays set until the next accepted start. The words already stored are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a flush run |
| half_period_i | input | 16 | Shift clock half-period in system cycles (0 is treated as 1) |
| len_bits_i | input | 16 | Number of bits to shift per chain |
| sdata_i | input | 2 | Serial data, one bit per chain |
| rd_en_i | input | 2 | FIFO read strobe, one per chain |
| sclk_o | output | 1 | Generated shift clock |
| shift_en_o | output | 1 | Shift enable for the chains |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run has finished |
| rd_data_o | output | 32 | Head word of each FIFO, chain 0 in bits 15:0 |
| empty_o | output | 2 | FIFO empty flag per chain |
| count_o | output | 10 | FIFO fill count per chain, 5 bits each, chain 0 in the low field |
| overflow_o | output | 2 | Sticky overflow flag per chain |

## Verification
The bench measures every phase of the shift clock at half-periods of 0, 1, 2, 3 and 5. A divider that is off by one, or that treats 0 literally, shows up as wrong phase widths. It counts rising edges against lengths of 7, 16, 32, 40 and 50, which catches a bit counter that stops one edge early or late. Lengths of 7, 40 and 50 end part way through a word, so a design that drops the final partial word, or aligns it to the low bits, produces wrong words in the scoreboard. Other cases cover a zero length, a start pulse injected in the middle of a run (a design that accepts it would change the edge count), a run of 17 words into a 16-entry FIFO that checks the overflow flag and the survival of the stored words, and read strobes on empty FIFOs.

// File: rtl/flush_pkg.sv
package flush_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } flush_state_e;

endpackage

// File: rtl/flush_seq.sv
module flush_seq
    import flush_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sample_o,
    output logic             last_o,
    output logic             clear_o
);

    typedef struct packed {
        flush_state_e     state;
        logic [DIV_W-1:0] half;
        logic [DIV_W-1:0] cnt;
        logic [LEN_W-1:0] left;
        logic             sclk;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic toggle;

    always_comb begin
        d        = q;
        sample_o = 1'b0;
        last_o   = 1'b0;
        clear_o  = 1'b0;
        toggle   = (q.cnt == (q.half - DIV_W'(1)));
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    clear_o = 1'b1;
                    d.done  = 1'b0;
                    if (len_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.state = ST_SHIFT;
                        d.half  = (half_i == '0) ? DIV_W'(1) : half_i;
                        d.left  = len_i;
                        d.cnt   = '0;
                        d.sclk  = 1'b0;
                    end
                end
            end
            ST_SHIFT: begin
                if (toggle) begin
                    d.cnt  = '0;
                    d.sclk = ~q.sclk;
                    if (!q.sclk) begin
                        sample_o = 1'b1;
                        d.left   = q.left - LEN_W'(1);
                        if (q.left == LEN_W'(1)) begin
                            last_o  = 1'b1;
                            d.state = ST_TAIL;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end
            ST_TAIL: begin
                if (toggle) begin
                    d.cnt   = '0;
                    d.sclk  = 1'b0;
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.half  <= DIV_W'(1);
            q.cnt   <= '0;
            q.left  <= '0;
            q.sclk  <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign busy_o = (q.state != ST_IDLE);
    assign done_o = q.done;

    // R3
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && q.state == ST_SHIFT && !sample_o) |=> (q.left == $past(q.left)));

    // R4
    sample_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> $rose(sclk_o));

endmodule

// File: rtl/chain_deser.sv
module chain_deser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              last_i,
    input  logic              sdata_i,
    input  logic              full_i,
    output logic              wr_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              ovf_o
);

    localparam int NB_W = $clog2(WORD_W);
    localparam logic [NB_W-1:0] LAST_IDX = NB_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [NB_W-1:0]   nb;
        logic              ovf;
    } des_t;

    des_t q, d;
    logic [WORD_W-1:0] nxt;
    logic              push;

    always_comb begin
        d       = q;
        push    = 1'b0;
        wr_o    = 1'b0;
        wdata_o = '0;
        nxt     = {q.sh[WORD_W-2:0], sdata_i};
        if (clear_i) begin
            d.ovf = 1'b0;
            d.nb  = '0;
            d.sh  = '0;
        end
        if (sample_i) begin
            if (q.nb == LAST_IDX || last_i) begin
                push    = 1'b1;
                wdata_o = nxt << (LAST_IDX - q.nb);
                d.nb    = '0;
                d.sh    = '0;
            end else begin
                d.sh = nxt;
                d.nb = q.nb + NB_W'(1);
            end
        end
        if (push) begin
            if (full_i) begin
                d.ovf = 1'b1;
            end else begin
                wr_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ovf_o = q.ovf;

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clear_i) |=> ovf_o);

endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       rd_i,
    output logic [W-1:0]               rdata_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        d     = q;
        do_wr = wr_i && !full_o;
        do_rd = rd_i && !empty_o;
        if (do_wr) d.wp = (q.wp == TOP) ? '0 : q.wp + AW'(1);
        if (do_rd) d.rp = (q.rp == TOP) ? '0 : q.rp + AW'(1);
        if (do_wr && !do_rd) d.cnt = q.cnt + CW'(1);
        else if (do_rd && !do_wr) d.cnt = q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wp] <= wdata_i;
    end

    assign rdata_o = mem[q.rp];
    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CW'(DEPTH));
    assign count_o = q.cnt;

    // R12
    fifo_no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !full_o);

    // R11
    fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // R11
    fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !empty_o && !wr_i) |=> (count_o == $past(count_o) - CW'(1)));

    // R11
    fifo_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && empty_o && !wr_i) |=> empty_o);

endmodule

// File: rtl/evt_chain_flush.sv
module evt_chain_flush #(
    parameter int NUM_CHAINS = 2,
    parameter int WORD_W     = 16,
    parameter int DEPTH      = 16,
    parameter int DIV_W      = 16,
    parameter int LEN_W      = 16,
    parameter int CW         = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [DIV_W-1:0]             half_period_i,
    input  logic [LEN_W-1:0]             len_bits_i,
    input  logic [NUM_CHAINS-1:0]        sdata_i,
    input  logic [NUM_CHAINS-1:0]        rd_en_i,
    output logic                         sclk_o,
    output logic                         shift_en_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [NUM_CHAINS*WORD_W-1:0] rd_data_o,
    output logic [NUM_CHAINS-1:0]        empty_o,
    output logic [NUM_CHAINS*CW-1:0]     count_o,
    output logic [NUM_CHAINS-1:0]        overflow_o
);

    logic sample, last, clear;

    flush_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .half_i   (half_period_i),
        .len_i    (len_bits_i),
        .sclk_o   (sclk_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .sample_o (sample),
        .last_o   (last),
        .clear_o  (clear)
    );

    assign shift_en_o = busy_o;

    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
        logic              wr, full;
        logic [WORD_W-1:0] wdata;

        chain_deser #(.WORD_W(WORD_W)) u_des (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear),
            .sample_i (sample),
            .last_i   (last),
            .sdata_i  (sdata_i[g]),
            .full_i   (full),
            .wr_o     (wr),
            .wdata_o  (wdata),
            .ovf_o    (overflow_o[g])
        );

        word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr),
            .wdata_i (wdata),
            .rd_i    (rd_en_i[g]),
            .rdata_o (rd_data_o[g*WORD_W +: WORD_W]),
            .empty_o (empty_o[g]),
            .full_o  (full),
            .count_o (count_o[g*CW +: CW])
        );
    end

endmodule

// File: tb/evt_chain_flush_tb.sv
module evt_chain_flush_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] half_period_i = '0;
    logic [15:0] len_bits_i = '0;
    logic [1:0]  sdata_i = '0;
    logic [1:0]  rd_en_i = '0;
    logic        sclk_o, shift_en_o, busy_o, done_o;
    logic [31:0] rd_data_o;
    logic [1:0]  empty_o, overflow_o;
    logic [9:0]  count_o;

    int checks = 0;
    int fails  = 0;
    bit drain  = 1'b0;
    bit src [2][0:1023];
    logic [15:0] exp_q0[$];
    logic [15:0] exp_q1[$];

    always #2 clk = ~clk;

    evt_chain_flush u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_period_i(half_period_i),
        .len_bits_i(len_bits_i), .sdata_i(sdata_i), .rd_en_i(rd_en_i), .sclk_o(sclk_o),
        .shift_en_o(shift_en_o), .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o),
        .empty_o(empty_o), .count_o(count_o), .overflow_o(overflow_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops each FIFO head as soon as it appears
    initial begin
        forever begin
            @(negedge clk);
            if (drain) begin
                rd_en_i = 2'b00;
                if (!empty_o[0]) begin
                    if (exp_q0.size() == 0) chk("R5 R10 chain0 unexpected word", {16'h0, rd_data_o[15:0]}, 32'hDEAD);
                    else chk("R5 R6 R10 chain0 word", {16'h0, rd_data_o[15:0]}, {16'h0, exp_q0.pop_front()});
                    rd_en_i[0] = 1'b1;
                end
                if (!empty_o[1]) begin
                    if (exp_q1.size() == 0) chk("R5 R10 chain1 unexpected word", {16'h0, rd_data_o[31:16]}, 32'hDEAD);
                    else chk("R5 R6 R10 chain1 word", {16'h0, rd_data_o[31:16]}, {16'h0, exp_q1.pop_front()});
                    rd_en_i[1] = 1'b1;
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    task automatic run_xfer(int h, int len, int cap, int inject_at);
        int eff = (h == 0) ? 1 : h;
        int idx = 0, rises = 0, run = 0, n = 0;
        bit prev = 1'b0, bad = 1'b0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 1024; i++) src[c][i] = (i < len) ? bit'($urandom % 2) : 1'b0;
        for (int w = 0; w * 16 < len && w < cap; w++) begin
            logic [15:0] a = '0, b = '0;
            for (int k = 0; k < 16; k++) begin
                if (w * 16 + k < len) begin
                    a[15-k] = src[0][w*16+k];
                    b[15-k] = src[1][w*16+k];
                end
            end
            exp_q0.push_back(a);
            exp_q1.push_back(b);
        end
        @(negedge clk);
        half_period_i = 16'(h);
        len_bits_i    = 16'(len);
        start_i       = 1'b1;
        sdata_i       = {src[1][0], src[0][0]};
        @(negedge clk);
        start_i = 1'b0;
        if (len == 0) begin
            chk("R9 busy after zero-length start", {31'h0, busy_o}, 32'h0);
            chk("R9 done after zero-length start", {31'h0, done_o}, 32'h1);
            repeat (3) begin
                @(negedge clk);
                chk("R9 no shift clock", {30'h0, busy_o, sclk_o}, 32'h0);
            end
            return;
        end
        chk("R2 busy and enable after start", {30'h0, busy_o, shift_en_o}, 32'h3);
        chk("R7 done cleared by start", {31'h0, done_o}, 32'h0);
        while (busy_o && n < 100000) begin
            bit s = sclk_o;
            if (s && !prev) begin
                rises++;
                idx++;
                if (idx < 1024) sdata_i = {src[1][idx], src[0][idx]};
            end
            if (s == prev) run++;
            else begin
                if (run != eff) bad = 1'b1;
                run = 1;
            end
            prev = s;
            n++;
            if (n == inject_at) begin
                start_i    = 1'b1;
                len_bits_i = 16'(len + 37);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        if (run != eff) bad = 1'b1;
        chk("R3 shift clock phase widths", {31'h0, bad}, 32'h0);
        if (inject_at > 0) chk("R8 edge count with start while busy", rises, len);
        else chk("R4 rising edge count", rises, len);
        chk("R7 done high, clock low at end", {30'h0, done_o, sclk_o}, 32'h2);
    endtask

    task automatic wait_drain();
        int n = 0;
        while ((exp_q0.size() != 0 || exp_q1.size() != 0 || empty_o != 2'b11) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk("R11 FIFOs empty after drain", {30'h0, empty_o}, 32'h3);
        chk("R5 no missing words", exp_q0.size() + exp_q1.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy/done/enable/clock", {28'h0, busy_o, done_o, shift_en_o, sclk_o}, 32'h0);
        chk("R1 FIFOs empty", {30'h0, empty_o}, 32'h3);
        chk("R1 counts zero", {22'h0, count_o}, 32'h0);
        chk("R1 overflow clear", {30'h0, overflow_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset release", {30'h0, busy_o, sclk_o}, 32'h0);
        drain = 1'b1;

        run_xfer(1, 32, 64, 0);  wait_drain();
        run_xfer(3, 40, 64, 0);  wait_drain();   // R6 partial of 8 bits
        run_xfer(0, 16, 64, 0);  wait_drain();   // R3 zero half-period
        run_xfer(2, 0, 64, 0);   wait_drain();   // R9
        run_xfer(2, 50, 64, 20); wait_drain();   // R8
        run_xfer(5, 7, 64, 0);   wait_drain();   // R6 short word

        // R12: 17 words into 16 entries, no draining
        drain = 1'b0;
        rd_en_i = 2'b00;
        run_xfer(1, 272, 16, 0);
        chk("R12 counts at full", {22'h0, count_o}, {22'h0, 5'd16, 5'd16});
        chk("R12 overflow set", {30'h0, overflow_o}, 32'h3);
        repeat (4) @(negedge clk);
        chk("R7 done holds", {31'h0, done_o}, 32'h1);
        chk("R12 overflow sticky", {30'h0, overflow_o}, 32'h3);
        drain = 1'b1;
        wait_drain();
        run_xfer(1, 16, 64, 0);
        chk("R12 overflow cleared by start", {30'h0, overflow_o}, 32'h0);
        wait_drain();

        // R11: read strobe on empty FIFOs
        drain = 1'b0;
        @(negedge clk);
        rd_en_i = 2'b11;
        @(negedge clk);
        rd_en_i = 2'b00;
        @(negedge clk);
        chk("R11 empty read ignored count", {22'h0, count_o}, 32'h0);
        chk("R11 empty read ignored flag", {30'h0, empty_o}, 32'h3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule